// File: doc/BRIEF.md
# Bidirectional Serial Byte Shifter

This block moves one byte at a time over a single serial data line, either sending or receiving. Its bit clock comes from one of three places: a pulse from an outside timer (each pulse toggles the bit-clock level), the system clock (each cycle toggles the level), or an external clock line. With an internal source, the block drives its bit clock onto the clock line for the far device. With the external source, it leaves the line undriven and follows its edges after synchronizing them.

Software writes a 3-bit mode word and then reads or writes the data register. Either access starts a transfer. Bits travel most significant first. Outgoing data changes on the falling bit-clock edge, and incoming data is sampled on the rising edge. After eight bits the shifter stops, returns the clock line to idle high and raises a completion flag. In the free-running send mode the byte recirculates without end.

Top module: `ser_shifter`

## Requirements
- R1: After reset, sclk_o and sdat_o are 1, irq_o and both output enables are 0, the mode is 000 and the data register reads 0x00.
- R2: addr_i=1 reads {irq, 0000, mode[2:0]}, and a write at addr_i=1 sets the mode. Mode bit 2 selects send (1) or receive (0). Bits 1:0 select the source: 00 none, 01 timer pulse, 10 system clock, 11 external. The code 100 is free-running send on the timer pulse.
- R3: In mode 000, a data access starts nothing. The clock stays high, irq stays 0, and a written byte reads back unchanged at addr_i=0.
- R4: In send mode the byte leaves MSB first. sdat_o changes after a falling bit-clock edge and is stable at the rising one. After 8 rising edges the clock rests high and irq_o is 1.
- R5: In receive mode, sdat_i is sampled on each rising bit-clock edge, MSB first. The received byte reads back at addr_i=0.
- R6: On the system clock, one bit takes 2 cycles. irq_o rises 16 cycles after the edge that accepts the starting access.
- R7: On the timer source, the bit-clock level toggles once per tick_i pulse and holds while no tick arrives.
- R8: On the external source, sclk_oe_o is 0, sclk_o stays 1, and shifting follows the synchronized edges of sclk_i.
- R9: In mode 100 the byte recirculates: the bit stream repeats every 8 bits, irq_o stays 0 and the clock keeps running.
- R10: Any data-register access clears irq_o and restarts the transfer. A mode write aborts a transfer and returns the clock to high.
- R11: sdat_oe_o equals mode bit 2. sclk_oe_o is 1 exactly when the mode is nonzero and its source bits are not 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 data, 1 mode/status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational on addr_i) |
| irq_o | output | 1 | Completion flag |
| tick_i | input | 1 | Timer underflow pulse |
| sclk_i | input | 1 | Clock line, input side |
| sclk_o | output | 1 | Clock line, output side |
| sclk_oe_o | output | 1 | Clock line drive enable |
| sdat_i | input | 1 | Data line, input side |
| sdat_o | output | 1 | Data line, output side |
| sdat_oe_o | output | 1 | Data line drive enable |

## Verification
Send and receive on the system clock are swept over all 256 byte values, which exposes bit-order, stuck-bit and count errors. All eight mode codes are read back and checked against both enables. Timer runs with gaps between ticks show the clock advancing only on pulses. External-clock runs show the synchronized edge path and that the block never drives the clock line. A free-running run of 24 bits separates recirculation from the stop-after-eight behaviour. Cycle-exact checks of irq timing, the clear on access and the abort on a mode write cover the control corners.

// File: rtl/ser_shifter_pkg.sv
package ser_shifter_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_SYS   = 2'b10,
    SRC_EXT   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic     out_dir;
    clk_src_e src;
  } mode_t;

  function automatic logic mode_free(mode_t m);
    return m.out_dir && (m.src == SRC_OFF);
  endfunction

  function automatic logic mode_enabled(mode_t m);
    return m.out_dir || (m.src != SRC_OFF);
  endfunction

  // free-running send runs on the timer pulse
  function automatic clk_src_e mode_src(mode_t m);
    return mode_free(m) ? SRC_TIMER : m.src;
  endfunction

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= (g == 0) ? d_i : stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_bitclk.sv
module ser_bitclk
  import ser_shifter_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     clear_i,
  input  clk_src_e src_i,
  input  logic     tick_i,
  input  logic     ext_rise_i,
  input  logic     ext_fall_i,
  output logic     fall_o,
  output logic     rise_o,
  output logic     sclk_o
);
  logic lvl_q;
  logic step;

  always_comb begin
    unique case (src_i)
      SRC_TIMER: step = tick_i;
      SRC_SYS:   step = 1'b1;
      default:   step = 1'b0;
    endcase
  end

  always_comb begin
    if (src_i == SRC_EXT) begin
      fall_o = active_i && ext_fall_i;
      rise_o = active_i && ext_rise_i;
    end else begin
      fall_o = active_i && step && lvl_q;
      rise_o = active_i && step && !lvl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lvl_q <= 1'b1;
    else if (!active_i || clear_i)  lvl_q <= 1'b1;
    else if (step)                  lvl_q <= ~lvl_q;
  end

  assign sclk_o = lvl_q;

  // R7: level only moves on a tick when on the timer source
  a_r7_tick_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !clear_i && (src_i == SRC_TIMER) && !tick_i |=> $stable(lvl_q));
endmodule

// File: rtl/ser_core.sv
module ser_core #(
  parameter int W = 8,
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_i,
  input  logic         start_i,
  input  logic         load_i,
  input  logic [W-1:0] wdata_i,
  input  logic         abort_i,
  input  logic         out_dir_i,
  input  logic         free_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         din_i,
  output logic [W-1:0] sr_o,
  output logic         dout_o,
  output logic         active_o,
  output logic         irq_o
);
  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, irq_q, dout_q;
  logic             last, shift_ok;

  assign last     = (cnt_q == CNT_W'(W-1));
  assign shift_ok = active_q && !start_i && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (acc_i) irq_q <= 1'b0;
      if (abort_i) begin
        active_q <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q && rise_i) begin
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        if (last && !free_i) begin
          active_q <= 1'b0;
          irq_q    <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b1;
    end else if (load_i) begin
      sr_q <= wdata_i;
    end else if (shift_ok) begin
      if (fall_i && out_dir_i) begin
        dout_q <= sr_q[W-1];
        sr_q   <= {sr_q[W-2:0], sr_q[W-1]};
      end else if (rise_i && !out_dir_i) begin
        sr_q <= {sr_q[W-2:0], din_i};
      end
    end
  end

  assign sr_o     = sr_q;
  assign dout_o   = dout_q;
  assign active_o = active_q;
  assign irq_o    = irq_q;

  // R4: completion flag only appears as the shifter stops
  a_r4_done_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> !active_q);
  // R9: free-running never stops by itself
  a_r9_free_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && free_i && !abort_i |=> active_q);
  // R6: bit count advances only on rising bit-clock edges
  a_r6_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !rise_i && !start_i |=> $stable(cnt_q));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_shifter_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              tick_i,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe_o
);
  localparam int PAD_W = DATA_W - 4;

  mode_t             mode_q;
  clk_src_e          src;
  logic              data_acc, start, load, abort;
  logic              busy, fall, rise, irq;
  logic              sclk_s, sdat_s, sclk_d;
  logic [DATA_W-1:0] sr;
  logic              din;

  assign data_acc = sel_i && (wr_i || rd_i) && !addr_i;
  assign start    = data_acc && mode_enabled(mode_q);
  assign load     = sel_i && wr_i && !addr_i;
  assign abort    = sel_i && wr_i && addr_i;
  assign src      = mode_src(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= '0;
    else if (abort) mode_q <= mode_t'(wdata_i[2:0]);
  end

  ser_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdat_i}),
    .q_o   ({sclk_s, sdat_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b1;
    else         sclk_d <= sclk_s;
  end

  assign din = (src == SRC_EXT) ? sdat_s : sdat_i;

  ser_bitclk u_bitclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (busy),
    .clear_i   (start || abort),
    .src_i     (src),
    .tick_i    (tick_i),
    .ext_rise_i(sclk_s && !sclk_d),
    .ext_fall_i(!sclk_s && sclk_d),
    .fall_o    (fall),
    .rise_o    (rise),
    .sclk_o    (sclk_o)
  );

  ser_core #(.W(DATA_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (data_acc),
    .start_i  (start),
    .load_i   (load),
    .wdata_i  (wdata_i),
    .abort_i  (abort),
    .out_dir_i(mode_q.out_dir),
    .free_i   (mode_free(mode_q)),
    .fall_i   (fall),
    .rise_i   (rise),
    .din_i    (din),
    .sr_o     (sr),
    .dout_o   (sdat_o),
    .active_o (busy),
    .irq_o    (irq)
  );

  assign irq_o     = irq;
  assign rdata_o   = addr_i ? {irq, {PAD_W{1'b0}}, mode_q} : sr;
  assign sdat_oe_o = mode_q.out_dir;
  assign sclk_oe_o = mode_enabled(mode_q) && (src != SRC_EXT);

  // R10: clock line rests high whenever no transfer runs
  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sclk_o);
  // R8: external source never drives or moves the clock line
  a_r8_ext_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_EXT) |-> (!sclk_oe_o && sclk_o));
endmodule

// File: tb/tb_ser_shifter.sv
module tb_ser_shifter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 0, wr_i = 0, rd_i = 0, addr_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, tick_i = 0, sclk_i = 1, sclk_o, sclk_oe_o;
  logic       sdat_i = 0, sdat_o, sdat_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_shifter dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .tick_i(tick_i), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    sel_i = 0; wr_i = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    sel_i = 1; rd_i = 1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk); @(negedge clk);
    sel_i = 0; rd_i = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // bench acts as far device on an internally clocked line
  task automatic run_int(input logic [7:0] tx, input int per, input int target,
                         input int max_cyc, output logic [31:0] rx, output int rises);
    logic prev, cur;
    rx = '0; rises = 0; prev = sclk_o;
    for (int c = 0; c < max_cyc && rises < target; c++) begin
      tick_i = (per > 0) && (c % per == per - 1);
      @(posedge clk); @(negedge clk);
      cur = sclk_o;
      if (prev && !cur) sdat_i = tx[7 - (rises % 8)];
      if (!prev && cur) begin rx = {rx[30:0], sdat_o}; rises++; end
      prev = cur;
    end
    tick_i = 0;
  endtask

  task automatic run_ext(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < 8; i++) begin
      sclk_i = 0; sdat_i = tx[7-i];
      repeat (6) @(negedge clk);
      rx = {rx[6:0], sdat_o};
      sclk_i = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] rx;
    int          n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk(sclk_o == 1 && sdat_o == 1, "R1 lines idle", {sclk_o, sdat_o}, 3);
    chk(irq_o == 0 && sclk_oe_o == 0 && sdat_oe_o == 0, "R1 flags",
        {irq_o, sclk_oe_o, sdat_oe_o}, 0);
    peek(1, d); chk(d == 8'h00, "R1 mode", d, 0);
    peek(0, d); chk(d == 8'h00, "R1 data", d, 0);

    // R2 R11 all mode codes
    for (int m = 0; m < 8; m++) begin
      bus_wr(1, 8'(m));
      peek(1, d); chk(d == 8'(m), "R2 mode readback", d, m);
      chk(sdat_oe_o == m[2], "R11 data enable", sdat_oe_o, m[2]);
      chk(sclk_oe_o == (m != 0 && m[1:0] != 2'b11), "R11 clock enable",
          sclk_oe_o, (m != 0 && m[1:0] != 2'b11));
    end

    // R3 disabled mode
    bus_wr(1, 8'h00);
    bus_wr(0, 8'h3C);
    n = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (!sclk_o || irq_o) n++; end
    chk(n == 0, "R3 no activity", n, 0);
    peek(0, d); chk(d == 8'h3C, "R3 data kept", d, 8'h3C);

    // R6 timing on system clock
    bus_wr(1, 8'h06);
    bus_wr(0, 8'h81);
    repeat (15) @(negedge clk);
    chk(irq_o == 0, "R6 irq not yet", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1, "R6 irq at 16", irq_o, 1);

    // R10 access clears flag and restarts
    peek(1, d); chk(d == 8'h86, "R2 status flag", d, 8'h86);
    bus_rd(0, d);
    chk(irq_o == 0 && sclk_o == 1, "R10 clear on access", {irq_o, sclk_o}, 1);
    @(negedge clk);
    chk(sclk_o == 0, "R10 restart", sclk_o, 0);
    repeat (3) @(negedge clk);
    bus_wr(1, 8'h06);
    n = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (!sclk_o || irq_o) n++; end
    chk(n == 0, "R10 abort by mode write", n, 0);

    // R4 send sweep on system clock
    for (int v = 0; v < 256; v++) begin
      bus_wr(0, 8'(v));
      run_int(8'h00, 0, 8, 40, rx, n);
      chk(rx[7:0] == 8'(v) && n == 8, "R4 send byte", rx[7:0], v);
      chk(irq_o == 1 && sclk_o == 1, "R4 stop and flag", {irq_o, sclk_o}, 3);
    end

    // R5 receive sweep on system clock
    bus_wr(1, 8'h02);
    for (int v = 0; v < 256; v++) begin
      bus_wr(0, 8'h00);
      run_int(8'(v), 0, 8, 40, rx, n);
      peek(0, d);
      chk(d == 8'(v) && irq_o == 1, "R5 receive byte", d, v);
    end

    // R7 timer source
    bus_wr(1, 8'h05);
    bus_wr(0, 8'hC3);
    run_int(8'h00, 0, 1, 20, rx, n);
    chk(n == 0 && sclk_o == 1, "R7 holds without tick", n, 0);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk(sclk_o == 0, "R7 tick toggles", sclk_o, 0);
    repeat (4) @(negedge clk);
    chk(sclk_o == 0, "R7 level holds", sclk_o, 0);
    bus_wr(0, 8'h5A);
    run_int(8'h00, 3, 8, 100, rx, n);
    chk(rx[7:0] == 8'h5A && irq_o == 1, "R7 timer send", rx[7:0], 8'h5A);
    bus_wr(1, 8'h01);
    bus_wr(0, 8'h00);
    run_int(8'hB7, 4, 8, 100, rx, n);
    peek(0, d); chk(d == 8'hB7, "R7 timer receive", d, 8'hB7);

    // R8 external clock
    foreach (rx[i]) ;
    bus_wr(1, 8'h07);
    chk(sclk_oe_o == 0, "R8 clock not driven", sclk_oe_o, 0);
    bus_wr(0, 8'h96);
    run_ext(8'h00, d);
    repeat (6) @(negedge clk);
    chk(d == 8'h96 && irq_o == 1, "R8 ext send", d, 8'h96);
    chk(sclk_o == 1, "R8 clock out idle", sclk_o, 1);
    bus_wr(1, 8'h03);
    bus_wr(0, 8'h00);
    run_ext(8'h2D, d);
    repeat (6) @(negedge clk);
    peek(0, d); chk(d == 8'h2D && irq_o == 1, "R8 ext receive", d, 8'h2D);

    // R9 free-running
    bus_wr(1, 8'h04);
    bus_wr(0, 8'hA5);
    run_int(8'h00, 2, 24, 200, rx, n);
    chk(rx[23:0] == 24'hA5A5A5, "R9 recirculate", rx[23:0], 24'hA5A5A5);
    chk(irq_o == 0, "R9 no flag", irq_o, 0);
    run_int(8'h00, 2, 2, 20, rx, n);
    chk(n == 2, "R9 keeps running", n, 2);
    run_int(8'h00, 2, 6, 40, rx, n);
    bus_wr(1, 8'h00);
    peek(0, d); chk(d == 8'hA5, "R9 byte intact", d, 8'hA5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule